// File: doc/BRIEF.md
# Three-Channel Shared-Table Waveform Generator

This block produces three streams of 8-bit waveform samples for external digital-to-analog converters. All three streams come from a single 1024-word lookup table. The table holds four 256-point, single-cycle shapes: a sine approximation, a rising ramp, a falling ramp and a triangle. A 2-bit shape select picks one of the four shapes, and that choice applies to all channels.

Each channel has its own 8-bit step index. Software sets the phase offsets between the channels by loading all three indices in one cycle from a 24-bit word. A sequencer cycles through four clocks per frame:

- In each of the first three clocks, one channel's index drives the low table address bits, and the table word is captured into that channel's holding register.
- In the fourth clock, an update strobe copies all three holding registers into the output registers at once. The converters therefore never see a partly updated set of samples.

The indices advance together once per frame. The shape select is sampled only at a frame boundary.

Top module: `mux_wave_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `sample_o` is 0 and `upd_o` is 0. Reset also clears all step indices to 0, sets the shape select in use to 0, and starts the sequencer in the channel-0 capture clock.
- R2: The table address is {shape select, step index i}. Shape 1 gives the value i. Shape 2 gives 255 - i.
- R3: Shape 0 gives a parabolic sine approximation. Let x = i mod 128 and s = floor(x*(127-x)/32). The value is 128 + s when i < 128, and 128 - s otherwise.
- R4: Shape 3 gives a triangle. The value is 2*i when i < 128, and 511 - 2*i otherwise.
- R5: A high `load_en` at a clock edge loads the channel-0 index from `load_data[7:0]`, channel 1 from [15:8] and channel 2 from [23:16]. The same edge samples `func_sel` and restarts the frame at the channel-0 capture clock. `sample_o` is not changed by this edge.
- R6: A frame lasts four clocks: capture channel 0, capture channel 1, capture channel 2, then update. `upd_o` is high only in the update clock.
- R7: `sample_o` changes only at the clock edge that ends an update clock. At that edge all three channel fields (channel k in bits [8k+7:8k]) change together.
- R8: At the edge that ends the channel-2 capture clock, every index increments by one, and 255 wraps to 0. The indices do not change at any other time, except when they are loaded.
- R9: `func_sel` is sampled only at the edge that ends an update clock, or at a load edge. Changes to it within a frame do not affect that frame's samples.
- R10: The samples presented after a frame's update edge equal the table value for the shape sampled at the frame start, at each channel's index value as it stood at the frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load the three step indices and restart the frame |
| load_data | input | 24 | Three 8-bit start indices; channel 0 in the low byte |
| func_sel | input | 2 | Shape select: 0 sine, 1 rising ramp, 2 falling ramp, 3 triangle |
| sample_o | output | 24 | Three 8-bit output samples; channel 0 in the low byte |
| upd_o | output | 1 | High in the update clock of each frame |

## Verification
The following properties are checked on every cycle:

- The sequencer steps through its four phases in order, with exactly one phase active at a time.
- The indices increment only after the channel-2 capture, or take the load word on a load.
- The outputs hold steady outside the update edge, and at that edge they take exactly the held samples.
- The shape select in use stays fixed within a frame.

Only the bench scenarios can show that the samples are correct:

- the table arithmetic for each shape;
- wrap of the index from 255 to 0;
- a mid-frame shape change that must not reach the current frame;
- a mid-frame reload that leaves the outputs untouched.

// File: rtl/mwg_pkg.sv
package mwg_pkg;

  typedef enum logic [1:0] {
    SHAPE_SINE = 2'd0,
    SHAPE_RISE = 2'd1,
    SHAPE_FALL = 2'd2,
    SHAPE_TRI  = 2'd3
  } shape_e;

  // Parabolic half-wave around mid-scale; peak offset is 126.
  function automatic logic [7:0] sine_point(input logic [7:0] idx);
    logic [12:0] prod;
    logic [7:0]  s;
    prod = {6'd0, idx[6:0]} * {6'd0, 7'd127 - idx[6:0]};
    s    = prod[12:5];
    return idx[7] ? (8'd128 - s) : (8'd128 + s);
  endfunction

  function automatic logic [7:0] tri_point(input logic [7:0] idx);
    return idx[7] ? ~{idx[6:0], 1'b0} : {idx[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] wave_point(input logic [1:0] sel, input logic [7:0] idx);
    case (shape_e'(sel))
      SHAPE_SINE: return sine_point(idx);
      SHAPE_RISE: return idx;
      SHAPE_FALL: return ~idx;
      default:    return tri_point(idx);
    endcase
  endfunction

endpackage

// File: rtl/mwg_phase_seq.sv
module mwg_phase_seq #(
  parameter int NUM_CH = 3,
  parameter int PH_W   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic [PH_W-1:0]   phase,
  output logic [NUM_CH-1:0] cap_en,
  output logic              step_en,
  output logic              upd_strobe
);
  localparam logic [PH_W-1:0] UPD_PH  = PH_W'(NUM_CH);
  localparam logic [PH_W-1:0] LAST_CH = PH_W'(NUM_CH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (restart)          phase <= '0;
    else if (phase == UPD_PH)  phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
    assign cap_en[i] = (phase == PH_W'(i));
  end

  assign step_en    = (phase == LAST_CH);
  assign upd_strobe = (phase == UPD_PH);
endmodule

// File: rtl/mwg_phase_ctr.sv
module mwg_phase_ctr #(
  parameter int NUM_CH = 3,
  parameter int IDX_W  = 8,
  parameter int PH_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NUM_CH*IDX_W-1:0] load_data,
  input  logic                    step,
  input  logic [PH_W-1:0]         phase,
  output logic [NUM_CH*IDX_W-1:0] cnt_flat,
  output logic [IDX_W-1:0]        addr_idx
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_flat[i*IDX_W +: IDX_W] <= '0;
      else if (load) cnt_flat[i*IDX_W +: IDX_W] <= load_data[i*IDX_W +: IDX_W];
      else if (step) cnt_flat[i*IDX_W +: IDX_W] <= cnt_flat[i*IDX_W +: IDX_W] + IDX_W'(1);
    end
  end

  // Time-division address mux: the active phase selects one index.
  always_comb begin
    addr_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (phase == PH_W'(i)) addr_idx = cnt_flat[i*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/mwg_wave_rom.sv
module mwg_wave_rom #(
  parameter int SEL_W  = 2,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SEL_W + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import mwg_pkg::*;
  assign data = DATA_W'(wave_point(2'(addr[IDX_W +: SEL_W]), 8'(addr[IDX_W-1:0])));
endmodule

// File: rtl/mwg_chan_buf.sv
module mwg_chan_buf #(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          cap_en,
  input  logic [SAMPLE_W-1:0]        rom_data,
  input  logic                       upd,
  output logic [NUM_CH*SAMPLE_W-1:0] hold_flat,
  output logic [NUM_CH*SAMPLE_W-1:0] sample_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_flat[i*SAMPLE_W +: SAMPLE_W] <= '0;
      else if (cap_en[i]) hold_flat[i*SAMPLE_W +: SAMPLE_W] <= rom_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sample_o <= '0;
    else if (upd) sample_o <= hold_flat;
  end
endmodule

// File: rtl/mux_wave_gen.sv
module mux_wave_gen #(
  parameter int NUM_CH   = 3,
  parameter int IDX_W    = 8,
  parameter int SEL_W    = 2,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [NUM_CH*IDX_W-1:0]    load_data,
  input  logic [SEL_W-1:0]           func_sel,
  output logic [NUM_CH*SAMPLE_W-1:0] sample_o,
  output logic                       upd_o
);
  localparam int PH_W   = $clog2(NUM_CH + 1);
  localparam int ADDR_W = SEL_W + IDX_W;

  logic [PH_W-1:0]            phase;
  logic [NUM_CH-1:0]          cap_en;
  logic                       step_en;
  logic                       upd_strobe;
  logic [NUM_CH*IDX_W-1:0]    cnt_flat;
  logic [IDX_W-1:0]           addr_idx;
  logic [SEL_W-1:0]           func_q;
  logic [ADDR_W-1:0]          rom_addr;
  logic [SAMPLE_W-1:0]        rom_data;
  logic [NUM_CH*SAMPLE_W-1:0] hold_flat;

  // Shape select is committed only at a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     func_q <= '0;
    else if (load_en || upd_strobe) func_q <= func_sel;
  end

  mwg_phase_seq #(.NUM_CH(NUM_CH), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(load_en), .phase(phase),
    .cap_en(cap_en), .step_en(step_en), .upd_strobe(upd_strobe)
  );

  mwg_phase_ctr #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .PH_W(PH_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_data(load_data),
    .step(step_en), .phase(phase), .cnt_flat(cnt_flat), .addr_idx(addr_idx)
  );

  assign rom_addr = {func_q, addr_idx};

  mwg_wave_rom #(.SEL_W(SEL_W), .IDX_W(IDX_W), .DATA_W(SAMPLE_W)) u_rom (
    .addr(rom_addr), .data(rom_data)
  );

  mwg_chan_buf #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .rom_data(rom_data),
    .upd(upd_strobe), .hold_flat(hold_flat), .sample_o(sample_o)
  );

  assign upd_o = upd_strobe;
endmodule

// File: rtl/mwg_checker.sv
module mwg_checker #(
  parameter int NUM_CH   = 3,
  parameter int IDX_W    = 8,
  parameter int SEL_W    = 2,
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       load_en,
  input logic [NUM_CH*IDX_W-1:0]    load_data,
  input logic [SEL_W-1:0]           func_q,
  input logic [NUM_CH-1:0]          cap_en,
  input logic                       step_en,
  input logic                       upd_strobe,
  input logic [NUM_CH*IDX_W-1:0]    cnt_flat,
  input logic [NUM_CH*SAMPLE_W-1:0] hold_flat,
  input logic [NUM_CH*SAMPLE_W-1:0] sample_o
);
  p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cap_en) + 32'(upd_strobe)) == 1);

  p_update_follows_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && cap_en[NUM_CH-1]) |=> upd_strobe);

  p_wrap_to_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && upd_strobe) |=> cap_en[0]);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> $stable(sample_o));

  p_out_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> sample_o == $past(hold_flat));

  p_idx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(cnt_flat));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_step
    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && step_en) |=>
        cnt_flat[i*IDX_W +: IDX_W] == IDX_W'($past(cnt_flat[i*IDX_W +: IDX_W]) + 1));
  end

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_flat == $past(load_data)) && cap_en[0]);

  p_shape_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !upd_strobe) |=> $stable(func_q));
endmodule

bind mux_wave_gen mwg_checker #(
  .NUM_CH(NUM_CH), .IDX_W(IDX_W), .SEL_W(SEL_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
  .func_q(func_q), .cap_en(cap_en), .step_en(step_en), .upd_strobe(upd_strobe),
  .cnt_flat(cnt_flat), .hold_flat(hold_flat), .sample_o(sample_o)
);

// File: tb/mux_wave_gen_bench.sv
`timescale 1ns/1ps
module mux_wave_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [23:0] load_data = '0;
  logic [1:0]  func_sel = '0;
  logic [23:0] sample_o;
  logic        upd_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  m_idx [3];
  logic [1:0]  cur_shape;
  logic [23:0] prev_out;

  always #2.5 clk = ~clk;

  mux_wave_gen u_mux_wave_gen (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .func_sel(func_sel), .sample_o(sample_o), .upd_o(upd_o)
  );

  function automatic int ref_point(input int shape, input int i);
    int x, s;
    case (shape)
      0: begin
        x = i % 128;
        s = (x * (127 - x)) / 32;
        return (i < 128) ? 128 + s : 128 - s;
      end
      1: return i;
      2: return 255 - i;
      default: return (i < 128) ? 2 * i : 511 - 2 * i;
    endcase
  endfunction

  function automatic logic [23:0] ref_frame(input int shape);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) r[c*8 +: 8] = 8'(ref_point(shape, int'(m_idx[c])));
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Entered at the negedge inside a channel-0 capture clock.
  task automatic run_frame(input logic [1:0] next_shape);
    logic [23:0] exp;
    string tag;
    exp = ref_frame(int'(cur_shape));
    chk("R6 strobe low while capturing", 32'(upd_o), 0);
    func_sel = 2'($urandom);              // R9: noise inside the frame
    tick();
    chk("R7 outputs held mid-frame", 32'(sample_o), 32'(prev_out));
    tick();
    func_sel = next_shape;
    tick();
    chk("R6 strobe high in update clock", 32'(upd_o), 1);
    chk("R7 outputs held until update edge", 32'(sample_o), 32'(prev_out));
    tick();
    case (cur_shape)
      2'd0:    tag = "R3 R10 sine samples";
      2'd3:    tag = "R4 R10 triangle samples";
      default: tag = "R2 R9 R10 ramp samples";
    endcase
    chk(tag, 32'(sample_o), 32'(exp));
    prev_out  = exp;
    cur_shape = next_shape;
    for (int c = 0; c < 3; c++) m_idx[c] = m_idx[c] + 8'd1;   // R8 wrap
  endtask

  // Entered at a negedge; leaves at the negedge inside the new capture-0 clock.
  task automatic do_load(input logic [23:0] d, input logic [1:0] shape);
    load_en   = 1'b1;
    load_data = d;
    func_sel  = shape;
    tick();
    load_en = 1'b0;
    chk("R5 frame restarts after load", 32'(upd_o), 0);
    chk("R5 R7 load leaves outputs", 32'(sample_o), 32'(prev_out));
    for (int c = 0; c < 3; c++) m_idx[c] = d[c*8 +: 8];
    cur_shape = shape;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs zero in reset", 32'(sample_o), 0);
    chk("R1 strobe low in reset", 32'(upd_o), 0);
    rst_n = 1'b1;
    chk("R1 outputs zero after release", 32'(sample_o), 0);
    for (int c = 0; c < 3; c++) m_idx[c] = 8'd0;
    cur_shape = 2'd0;
    prev_out  = '0;

    // Free run from reset state: indices 0, sine.
    run_frame(2'd1);
    run_frame(2'd2);
    run_frame(2'd3);

    // Directed phase offsets, every shape.
    do_load({8'd200, 8'd100, 8'd10}, 2'd0);
    run_frame(2'd1);
    run_frame(2'd2);
    run_frame(2'd3);
    run_frame(2'd0);

    // R8: wrap from 255 to 0, triangle peak at 127/128.
    do_load({8'd0, 8'd255, 8'd254}, 2'd3);
    run_frame(2'd3);
    run_frame(2'd3);
    run_frame(2'd1);
    do_load({8'd128, 8'd127, 8'd255}, 2'd3);
    run_frame(2'd0);
    run_frame(2'd2);

    // R5: reload in the middle of a frame.
    tick();
    do_load({8'd64, 8'd32, 8'd192}, 2'd2);
    run_frame(2'd0);
    tick();
    tick();
    do_load({8'd1, 8'd2, 8'd3}, 2'd1);
    run_frame(2'd1);

    // Random shapes and offsets.
    for (int k = 0; k < 60; k++) begin
      if (($urandom % 8) == 0) do_load(24'($urandom), 2'($urandom));
      run_frame(2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule